// File: doc/BRIEF.md
# Speculative Load Conflict Table

This block tracks loads that a compiler has hoisted above stores whose addresses were not known at schedule time. When such an early load executes, its destination register tag is recorded together with the byte range it read. Every store that executes afterwards is compared against all live records. A store whose bytes overlap a recorded range removes that record. When the program reaches the point where the load would have sat originally, it asks the table about the register tag. A hit means that no store disturbed the data and the early value can be kept. A miss means that the load must be executed again.

The table is fully associative and keyed by register tag, not by address. A lost record is never a correctness problem, because it only causes a needless reissue. For this reason the table may evict records when it runs out of space. A store port and an insert port can act in the same cycle as a check. A check can optionally consume the record it finds.

Top module: `spec_load_table`

## Requirements
- R1: Synchronous active-low reset empties the table and clears `chk_resp_valid`. Every check issued after reset misses until a new insert is made.
- R2: Each cycle with `chk_valid` high produces `chk_resp_valid` high in exactly the next cycle, and every other cycle has it low. `chk_hit` is high only together with `chk_resp_valid`.
- R3: After an insert, a later check of the same tag hits as long as no overlapping store and no eviction has occurred in between.
- R4: Size codes are 0, 1, 2 and 3, meaning 1, 2, 4 and 8 bytes. A range runs from addr to addr+bytes. Two ranges overlap when each start lies below the other's end. A store whose range overlaps a record invalidates it. Merely adjacent ranges do not overlap.
- R5: A single store invalidates every overlapping record in the same cycle and leaves the records that do not overlap.
- R6: An insert whose tag is already live rewrites that record in place with the new range. It takes no second entry, and the old range no longer matters.
- R7: An insert of a new tag takes the lowest-numbered free entry. When all entries are live, it evicts one chosen by a round-robin pointer. The pointer starts at entry 0 after reset and advances only on an eviction. A later check of the evicted tag misses.
- R8: An insert and an overlapping store in the same cycle leave no live record for the inserted tag.
- R9: A check with `chk_clear` high invalidates the record it hits. A plain check leaves the record in place.
- R10: A check sees the table as it stood before the same cycle's insert, store and clear take effect.
- R11: No two live entries ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Record an early load this cycle |
| ins_tag | input | TAG_W | Destination register tag of the early load |
| ins_addr | input | ADDR_W | Start byte address of the early load |
| ins_size | input | 2 | Size code of the early load (R4) |
| st_valid | input | 1 | A store executes this cycle |
| st_addr | input | ADDR_W | Start byte address of the store |
| st_size | input | 2 | Size code of the store (R4) |
| chk_valid | input | 1 | Query the table this cycle |
| chk_tag | input | TAG_W | Register tag to query |
| chk_clear | input | 1 | Invalidate the record on a hit |
| chk_resp_valid | output | 1 | Response to the previous cycle's query |
| chk_hit | output | 1 | Record found (keep the early value) |

## Verification
The only place the table's state can be seen is `chk_hit`, one cycle after a check. A corrupted valid bit, tag or range therefore shows up only on the next check of the affected tag. A stale record gives a false hit, which is the dangerous case. A dropped record gives an extra miss. Faults in the replacement pointer stay hidden until the table is full and an eviction takes place. For that reason the stimulus fills the table on purpose and then checks exactly which tag left it. Overlap faults appear at the byte boundaries, so stores are placed adjacent to records and overlapping them by a single byte.

// File: rtl/slt_pkg.sv
// Shared definitions for the speculative load conflict table.
// Assumes access sizes are naturally encoded as a power-of-two byte count.
package slt_pkg;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;

    // Byte count of an access size code.
    function automatic logic [3:0] size_bytes(input acc_size_e sz);
        return 4'd1 << sz;
    endfunction

endpackage

// File: rtl/slt_overlap.sv
// Byte range overlap compare between a recorded access and a store.
// Assumes: ranges are half-open [addr, addr+bytes). The end is computed one bit
// wider so that a range reaching the top of the address space does not wrap.
module slt_overlap #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [1:0]        a_size,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [1:0]        b_size,
    output logic              hit
);
    localparam int EW = ADDR_W + 1;

    logic [EW-1:0] a_lo, a_hi, b_lo, b_hi;

    // Form both ranges and test whether each start lies below the other's end.
    always_comb begin
        a_lo = {1'b0, a_addr};
        b_lo = {1'b0, b_addr};
        a_hi = a_lo + EW'(slt_pkg::size_bytes(slt_pkg::acc_size_e'(a_size)));
        b_hi = b_lo + EW'(slt_pkg::size_bytes(slt_pkg::acc_size_e'(b_size)));
        hit  = (a_lo < b_hi) && (b_lo < a_hi);
    end

endmodule

// File: rtl/slt_tag_match.sv
// Parallel tag compare across all entries; only live entries may match.
// Assumes the caller keeps tags unique among live entries.
module slt_tag_match #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 7
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]              key,
    output logic [ENTRIES-1:0]            match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // One comparator per entry.
        assign match[g] = vld[g] && (tags[g] == key);
    end

endmodule

// File: rtl/slt_alloc.sv
// Entry selection for an insert: tag match first, then lowest free entry,
// then the round-robin victim. Owns the round-robin pointer.
// Assumes ENTRIES >= 2 and that at most one entry matches.
module slt_alloc #(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [ENTRIES-1:0] vld,
    input  logic [ENTRIES-1:0] match,
    output logic [IDX_W-1:0]   sel
);
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] match_idx, free_idx;
    logic             any_match, any_free;

    // Priority-encode the matching entry and the lowest free entry.
    always_comb begin
        match_idx = '0;
        free_idx  = '0;
        any_match = 1'b0;
        any_free  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i] && !any_match) begin
                match_idx = IDX_W'(i);
                any_match = 1'b1;
            end
            if (!vld[i] && !any_free) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    // Choose the target entry in priority order.
    always_comb begin
        if (any_match)     sel = match_idx;
        else if (any_free) sel = free_idx;
        else               sel = rr_ptr;
    end

    // Advance the victim pointer only when an eviction actually happens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (req && !any_match && !any_free) begin
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/spec_load_table.sv
// Speculative load conflict table. It records early loads by destination tag
// with their byte range, kills records hit by overlapping stores, and answers
// tag queries one cycle later.
// Update order within a cycle: check-clear, then insert, then store kill.
// A query always sees the state at the start of the cycle.
module spec_load_table #(
    parameter  int ENTRIES = 8,
    parameter  int TAG_W   = 7,
    parameter  int ADDR_W  = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [1:0]        ins_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    input  logic              chk_clear,
    output logic              chk_resp_valid,
    output logic              chk_hit
);
    // Entry storage.
    logic [ENTRIES-1:0]             ent_vld;
    logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    logic [ENTRIES-1:0][1:0]        ent_size;

    // Staged state after clear and insert.
    logic [ENTRIES-1:0]             clr_vld;
    logic [ENTRIES-1:0]             stg_vld;
    logic [ENTRIES-1:0][TAG_W-1:0]  stg_tag;
    logic [ENTRIES-1:0][ADDR_W-1:0] stg_addr;
    logic [ENTRIES-1:0][1:0]        stg_size;
    logic [ENTRIES-1:0]             nxt_vld;

    logic [ENTRIES-1:0] chk_match;
    logic [ENTRIES-1:0] ins_match;
    logic [ENTRIES-1:0] kill;
    logic [IDX_W-1:0]   ins_sel;

    // Query lookup against the current state.
    slt_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_chk_match (
        .vld   (ent_vld),
        .tags  (ent_tag),
        .key   (chk_tag),
        .match (chk_match)
    );

    // Drop the record that a consuming check hit.
    always_comb begin
        clr_vld = ent_vld;
        if (chk_valid && chk_clear) clr_vld = ent_vld & ~chk_match;
    end

    // Insert lookup against the post-clear state.
    slt_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_ins_match (
        .vld   (clr_vld),
        .tags  (ent_tag),
        .key   (ins_tag),
        .match (ins_match)
    );

    slt_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (ins_valid),
        .vld   (clr_vld),
        .match (ins_match),
        .sel   (ins_sel)
    );

    // Write the inserted record into the staged copy.
    always_comb begin
        stg_vld  = clr_vld;
        stg_tag  = ent_tag;
        stg_addr = ent_addr;
        stg_size = ent_size;
        if (ins_valid) begin
            stg_vld[ins_sel]  = 1'b1;
            stg_tag[ins_sel]  = ins_tag;
            stg_addr[ins_sel] = ins_addr;
            stg_size[ins_sel] = ins_size;
        end
    end

    // Store snoop compares run on the staged copy so a same-cycle insert is covered.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_snoop
        slt_overlap #(.ADDR_W(ADDR_W)) u_ovl (
            .a_addr (stg_addr[g]),
            .a_size (stg_size[g]),
            .b_addr (st_addr),
            .b_size (st_size),
            .hit    (kill[g])
        );
    end

    // Apply store kills last.
    always_comb begin
        nxt_vld = st_valid ? (stg_vld & ~kill) : stg_vld;
    end

    // Commit the table state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld  <= '0;
            ent_tag  <= '0;
            ent_addr <= '0;
            ent_size <= '0;
        end else begin
            ent_vld  <= nxt_vld;
            ent_tag  <= stg_tag;
            ent_addr <= stg_addr;
            ent_size <= stg_size;
        end
    end

    // Register the query response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_resp_valid <= 1'b0;
            chk_hit        <= 1'b0;
        end else begin
            chk_resp_valid <= chk_valid;
            chk_hit        <= chk_valid && (|chk_match);
        end
    end

endmodule

// File: rtl/slt_checker.sv
// Protocol and state checks for spec_load_table, attached by bind.
// Observes the ports and the live valid and tag vectors of the entries.
module slt_checker #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 7,
    parameter int ADDR_W  = 64
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           ins_valid,
    input logic [TAG_W-1:0]               ins_tag,
    input logic [ADDR_W-1:0]              ins_addr,
    input logic [1:0]                     ins_size,
    input logic                           st_valid,
    input logic [ADDR_W-1:0]              st_addr,
    input logic [1:0]                     st_size,
    input logic                           chk_valid,
    input logic [TAG_W-1:0]               chk_tag,
    input logic                           chk_clear,
    input logic                           chk_resp_valid,
    input logic                           chk_hit,
    input logic [ENTRIES-1:0]             ent_vld,
    input logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag
);
    // Independent overlap rule for the checker.
    function automatic logic ranges_meet(input logic [ADDR_W-1:0] a, input logic [1:0] asz,
                                         input logic [ADDR_W-1:0] b, input logic [1:0] bsz);
        logic [ADDR_W:0] ae, be;
        ae = {1'b0, a} + ((ADDR_W+1)'(1) << asz);
        be = {1'b0, b} + ((ADDR_W+1)'(1) << bsz);
        return ({1'b0, a} < be) && ({1'b0, b} < ae);
    endfunction

    // Whether a tag is live anywhere in the table.
    function automatic logic tag_live(input logic [ENTRIES-1:0] v,
                                      input logic [ENTRIES-1:0][TAG_W-1:0] t,
                                      input logic [TAG_W-1:0] k);
        logic f;
        f = 1'b0;
        for (int i = 0; i < ENTRIES; i++) if (v[i] && t[i] == k) f = 1'b1;
        return f;
    endfunction

    logic ins_st_ovl;
    logic dup_tag;

    // Overlap of the same-cycle insert and store.
    always_comb ins_st_ovl = ins_valid && st_valid &&
                             ranges_meet(ins_addr, ins_size, st_addr, st_size);

    // Detect two live entries with equal tags.
    always_comb begin
        dup_tag = 1'b0;
        for (int i = 0; i < ENTRIES; i++)
            for (int j = i + 1; j < ENTRIES; j++)
                if (ent_vld[i] && ent_vld[j] && ent_tag[i] == ent_tag[j]) dup_tag = 1'b1;
    end

    assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_resp_valid);

    assert_resp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !chk_resp_valid);

    assert_hit_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_hit |-> chk_resp_valid);

    assert_insert_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_st_ovl) |=> tag_live(ent_vld, ent_tag, $past(ins_tag)));

    assert_same_cycle_kill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_st_ovl |=> !tag_live(ent_vld, ent_tag, $past(ins_tag)));

    assert_clear_consumes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_clear && !(ins_valid && ins_tag == chk_tag))
        |=> !tag_live(ent_vld, ent_tag, $past(chk_tag)));

    assert_unique_tags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_tag);

endmodule

bind spec_load_table slt_checker #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .ADDR_W  (ADDR_W)
) u_slt_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .ins_valid      (ins_valid),
    .ins_tag        (ins_tag),
    .ins_addr       (ins_addr),
    .ins_size       (ins_size),
    .st_valid       (st_valid),
    .st_addr        (st_addr),
    .st_size        (st_size),
    .chk_valid      (chk_valid),
    .chk_tag        (chk_tag),
    .chk_clear      (chk_clear),
    .chk_resp_valid (chk_resp_valid),
    .chk_hit        (chk_hit),
    .ent_vld        (ent_vld),
    .ent_tag        (ent_tag)
);

// File: tb/spec_load_table_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues the expected hit or miss per check, and
// a monitor pops and compares at each response.
module spec_load_table_bench;
    localparam int TAG_W  = 7;
    localparam int ADDR_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ins_valid = 1'b0;
    logic [TAG_W-1:0]  ins_tag = '0;
    logic [ADDR_W-1:0] ins_addr = '0;
    logic [1:0]        ins_size = '0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [1:0]        st_size = '0;
    logic              chk_valid = 1'b0;
    logic [TAG_W-1:0]  chk_tag = '0;
    logic              chk_clear = 1'b0;
    logic              chk_resp_valid;
    logic              chk_hit;

    int    checks = 0;
    int    errors = 0;
    bit    exp_q[$];
    string req_q[$];

    always #2.5 clk = ~clk;

    spec_load_table u_spec_load_table (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_addr(ins_addr), .ins_size(ins_size),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
        .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_clear(chk_clear),
        .chk_resp_valid(chk_resp_valid), .chk_hit(chk_hit)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One cycle of stimulus on any combination of the three ports.
    task automatic cyc(input bit iv, input int itag, input logic [63:0] ia, input int isz,
                       input bit sv, input logic [63:0] sa, input int ssz,
                       input bit cv, input int ctag, input bit cclr,
                       input bit cexp, input string req);
        ins_valid = iv; ins_tag = TAG_W'(itag); ins_addr = ia; ins_size = 2'(isz);
        st_valid  = sv; st_addr = sa; st_size = 2'(ssz);
        chk_valid = cv; chk_tag = TAG_W'(ctag); chk_clear = cclr;
        if (cv) begin
            exp_q.push_back(cexp);
            req_q.push_back(req);
        end
        tick();
        ins_valid = 1'b0; st_valid = 1'b0; chk_valid = 1'b0; chk_clear = 1'b0;
    endtask

    task automatic ins(input int tag, input logic [63:0] a, input int sz);
        cyc(1, tag, a, sz, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic store(input logic [63:0] a, input int sz);
        cyc(0, 0, 0, 0, 1, a, sz, 0, 0, 0, 0, "");
    endtask

    task automatic check(input int tag, input bit clr, input bit exp, input string req);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, tag, clr, exp, req);
    endtask

    task automatic do_reset();
        tick(); tick();
        rst_n = 1'b0;
        tick(); tick();
        @(negedge clk);
        checks++;
        if (chk_resp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 chk_resp_valid in reset: actual %b expected 0", chk_resp_valid);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    // Monitor: pop and compare each response.
    always @(negedge clk) begin
        if (rst_n && chk_resp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 response without request: actual 1 expected 0");
            end else begin
                bit    e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                if (chk_hit !== e) begin
                    errors++;
                    $display("FAIL %s chk_hit actual %b expected %b", r, chk_hit, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: empty after reset
        check(5, 0, 0, "R1");
        // R3 and R4: insert 0x1000 size 4B, probe boundaries
        ins(3, 64'h1000, 2);
        check(3, 0, 1, "R3");
        store(64'h2000, 3);
        check(3, 0, 1, "R4 far store");
        store(64'h1004, 0);
        check(3, 0, 1, "R4 adjacent above");
        store(64'h0FFC, 2);
        check(3, 0, 1, "R4 adjacent below");
        store(64'h1003, 0);
        check(3, 0, 0, "R4 last byte overlap");
        // R5: one store kills two records, spares a third
        ins(10, 64'h100, 3);
        ins(11, 64'h104, 1);
        ins(12, 64'h200, 3);
        store(64'h104, 2);
        check(10, 0, 0, "R5");
        check(11, 0, 0, "R5");
        check(12, 0, 1, "R5");
        // R6: rewrite moves the range
        ins(20, 64'h300, 3);
        ins(20, 64'h400, 3);
        store(64'h300, 3);
        check(20, 0, 1, "R6 old range ignored");
        store(64'h404, 0);
        check(20, 0, 0, "R6 new range tracked");

        do_reset();
        check(12, 0, 0, "R1 cleared by reset");
        check(20, 0, 0, "R1 cleared by reset");
        // R8: same-cycle insert and store
        cyc(1, 30, 64'h800, 3, 1, 64'h806, 0, 0, 0, 0, 0, "");
        check(30, 0, 0, "R8 same-cycle kill");
        cyc(1, 31, 64'h900, 3, 1, 64'h908, 0, 0, 0, 0, 0, "");
        check(31, 0, 1, "R8 adjacent survives");
        // R9: plain checks keep, clearing check consumes
        ins(40, 64'hA00, 3);
        check(40, 0, 1, "R9 plain");
        check(40, 0, 1, "R9 plain keeps");
        check(40, 1, 1, "R9 clear hit");
        check(40, 0, 0, "R9 consumed");
        check(41, 1, 0, "R9 clear miss");
        // R10: check sees pre-update state
        cyc(1, 50, 64'hC00, 3, 0, 0, 0, 1, 50, 0, 0, "R10 insert not yet visible");
        check(50, 0, 1, "R10 visible next cycle");
        ins(51, 64'hD00, 3);
        cyc(0, 0, 0, 0, 1, 64'hD00, 0, 1, 51, 0, 1, "R10 store not yet applied");
        check(51, 0, 0, "R10 store applied");
        tick();
        checks++;
        @(negedge clk);
        if (chk_resp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle response: actual %b expected 0", chk_resp_valid);
        end
        @(posedge clk); #1;

        // R7: fill, round-robin eviction, free entry preferred
        do_reset();
        for (int k = 1; k <= 8; k++) ins(k, 64'(k) * 64'h1000, 3);
        ins(9, 64'h9000, 3);
        check(1, 0, 0, "R7 entry 0 evicted");
        check(2, 0, 1, "R7");
        check(9, 0, 1, "R7");
        ins(10, 64'hA000, 3);
        check(2, 0, 0, "R7 entry 1 evicted");
        check(3, 0, 1, "R7");
        store(64'h5000, 3);
        ins(11, 64'hB000, 3);
        check(11, 0, 1, "R7 free entry used");
        check(3, 0, 1, "R7 no eviction when free");
        ins(12, 64'hC000, 3);
        check(3, 0, 0, "R7 entry 2 evicted");
        check(4, 0, 1, "R7");

        // R6: rewrite takes no extra entry
        do_reset();
        for (int k = 1; k <= 7; k++) ins(k, 64'(k) * 64'h1000, 3);
        ins(1, 64'h1000, 3);
        ins(8, 64'h8000, 3);
        ins(9, 64'h9000, 3);
        check(1, 0, 0, "R6 single entry for rewrite");
        check(8, 0, 1, "R6");
        check(2, 0, 1, "R6");

        tick(); tick(); tick();
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R2 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule